// File: doc/BRIEF.md
# Indirect-Access Processor Register Port

This block is the processor-facing side of a switching device. It behaves as an 8-bit parallel bus slave with a data input and output, a single address line, and active-low chip select, write strobe and read strobe. The address line picks one of two direct locations. With the address line high, a write loads the mode register and a read returns the status byte. With the address line low, the location is the indirect access port.

Everything behind the indirect port takes three consecutive byte writes: a control byte, an index byte and a data byte. The two top control bits decide the target. Both set means an internal register: the configuration register at index FE (hex) or the clock-shift register at index FD. Any other value means the connection memory, which sits behind a simple request port. Control bit 0 marks a read. A read result is kept in a holding register and is fetched later by reading the indirect port. Direct accesses may fall between the three bytes without upsetting the sequence.

A busy flag is raised while the connection memory is being cleared after reset, and again for a fixed number of cycles after each completed indirect transaction. Indirect writes that arrive while busy is set are dropped.

Top module: `ind_bus_port`

## Requirements
- R1: After reset, the mode and configuration registers read 8'hFF and the clock-shift register reads 8'h00.
- R2: With the address line high, a write loads the mode register, and a read returns the status byte: bit 7 busy, bits 6:5 the number of indirect bytes accepted so far in the current sequence (0, 1 or 2), bit 0 bit 8 of the held read data, all other bits 0.
- R3: Three accepted writes with the address line low form one transaction: control byte, then index byte, then data byte. The third byte completes the transaction and returns the position count to 0.
- R4: When control bits 7:6 are 2'b11, the transaction targets a register: index 8'hFE is the configuration register, 8'hFD the clock-shift register, and no memory request is made. Any other value of bits 7:6 issues one memory request at the index as address. A write stores 9 bits: control bit 1 as bit 8 and the data byte as bits 7:0.
- R5: Control bit 0 set makes the transaction a read, and its data byte is ignored. Once busy has fallen, reading the indirect port returns bits 7:0 of the result, and status bit 0 carries bit 8. A register read yields the register value with bit 8 clear.
- R6: Writes to the mode register and reads of the status byte made between the bytes of a transaction leave its position and collected bytes unchanged.
- R7: Busy stays high for exactly BUSY_CYC cycles after a transaction completes. An indirect write that starts while busy is high changes nothing.
- R8: After reset, the block writes zero to every memory address in ascending order from 0, one per cycle, and holds busy high until the last write has been issued.
- R9: A write strobe acts once, in its first active cycle. Holding it low for longer has no further effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | Selects direct location: 1 mode/status, 0 indirect port |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when no read is active |
| busy | output | 1 | Busy flag |
| mode_q | output | 8 | Mode register |
| cfg_q | output | 8 | Configuration register |
| csh_q | output | 8 | Clock-shift register |
| cm_req | output | 1 | Memory request, one cycle per access |
| cm_we | output | 1 | Memory request is a write |
| cm_addr | output | AW | Memory address |
| cm_wdata | output | 9 | Memory write data |
| cm_rdata | input | 9 | Memory read data, valid the cycle after a read request |

## Verification
A sequence counter that slips shows up at once in status bits 6:5. On the next transaction it also shows up as a memory write at the wrong address or with the wrong data. A busy counter that is off by one changes the measured busy run. It also lets an indirect write that should be dropped get through, and that write then shifts the status position field. A stale or mis-timed read capture returns the wrong byte on the first indirect read after busy falls. A clear walk that skips addresses leaves nonzero memory words behind, and the bench finds them within a few hundred cycles of reset.

// File: rtl/ind_bus_port.sv
module ind_bus_port #(
  parameter int AW = 8,
  parameter int BUSY_CYC = 6,
  parameter logic [7:0] CFG_IDX = 8'hFE,
  parameter logic [7:0] CSH_IDX = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          a0,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          busy,
  output logic [7:0]    mode_q,
  output logic [7:0]    cfg_q,
  output logic [7:0]    csh_q,
  output logic          cm_req,
  output logic          cm_we,
  output logic [AW-1:0] cm_addr,
  output logic [8:0]    cm_wdata,
  input  logic [8:0]    cm_rdata
);
  localparam int BCW = $clog2(BUSY_CYC + 1);
  localparam logic [AW-1:0] LAST_A = AW'((1 << AW) - 1);

  logic wr_act, wr_act_d, rd_act, wr_go;
  logic [1:0] seq;
  logic [7:0] ctl_q, adr_q;
  logic [BCW-1:0] bcnt;
  logic clr;
  logic [AW-1:0] clr_a;
  logic [8:0] hold;
  logic rd_pend, rd_cap;
  logic iar_wr, last, is_reg, is_rd;
  logic [7:0] reg_rd;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n;
  assign wr_go  = wr_act && !wr_act_d;
  assign busy   = clr || (bcnt != '0);
  assign iar_wr = wr_go && !a0 && !busy;
  assign last   = iar_wr && (seq == 2'd2);
  assign is_reg = (ctl_q[7:6] == 2'b11);
  assign is_rd  = ctl_q[0];
  assign reg_rd = (adr_q == CFG_IDX) ? cfg_q : (adr_q == CSH_IDX) ? csh_q : 8'h00;

  assign dout = !rd_act ? 8'h00 :
                a0 ? {busy, seq, 4'b0000, hold[8]} : hold[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_d <= 1'b0;
      seq      <= 2'd0;
      ctl_q    <= 8'h00;
      adr_q    <= 8'h00;
      bcnt     <= '0;
      clr      <= 1'b1;
      clr_a    <= '0;
      hold     <= 9'h000;
      rd_pend  <= 1'b0;
      rd_cap   <= 1'b0;
      mode_q   <= 8'hFF;
      cfg_q    <= 8'hFF;
      csh_q    <= 8'h00;
      cm_req   <= 1'b0;
      cm_we    <= 1'b0;
      cm_addr  <= '0;
      cm_wdata <= 9'h000;
    end else begin
      wr_act_d <= wr_act;
      cm_req   <= 1'b0;
      cm_we    <= 1'b0;
      rd_pend  <= 1'b0;
      rd_cap   <= rd_pend;
      if (rd_cap) hold <= cm_rdata;
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (wr_go && a0) mode_q <= din;

      if (clr) begin
        cm_req   <= 1'b1;
        cm_we    <= 1'b1;
        cm_addr  <= clr_a;
        cm_wdata <= 9'h000;
        clr_a    <= clr_a + 1'b1;
        if (clr_a == LAST_A) clr <= 1'b0;
      end

      if (iar_wr) begin
        case (seq)
          2'd0: begin ctl_q <= din; seq <= 2'd1; end
          2'd1: begin adr_q <= din; seq <= 2'd2; end
          default: seq <= 2'd0;
        endcase
      end

      if (last) begin
        bcnt <= BCW'(BUSY_CYC);
        if (is_reg) begin
          if (is_rd) hold <= {1'b0, reg_rd};
          else begin
            if (adr_q == CFG_IDX) cfg_q <= din;
            if (adr_q == CSH_IDX) csh_q <= din;
          end
        end else begin
          cm_req   <= 1'b1;
          cm_we    <= !is_rd;
          cm_addr  <= adr_q[AW-1:0];
          cm_wdata <= {ctl_q[1], din};
          rd_pend  <= is_rd;
        end
      end
    end
  end

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_go && !a0 |=> $stable(seq) && $stable(ctl_q) && $stable(adr_q));

  p_direct_keeps_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && a0 |=> $stable(seq));

  p_third_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && !a0 && !busy && seq == 2'd2 |=> seq == 2'd0 && busy);

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cm_req && cm_we && cm_wdata == 9'h000);

  p_once_per_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act && wr_act_d |=> $stable(mode_q) && $stable(seq));

  p_reg_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last && is_reg |=> !cm_req);
endmodule

// File: tb/ind_bus_port_test.sv
module ind_bus_port_test;
  localparam int BC = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, mode_q, cfg_q, csh_q;
  logic busy, cm_req, cm_we;
  logic [7:0] cm_addr;
  logic [8:0] cm_wdata;
  logic [8:0] cm_rdata = 9'h000;
  logic [8:0] mem [256];
  int n_run = 0, n_fail = 0;
  int run_len = 0, last_run = 0;
  bit clr_phase = 1'b0;
  int clr_next = 0, clr_bad = 0;

  always #2 clk = ~clk;

  ind_bus_port #(.AW(8), .BUSY_CYC(BC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .a0(a0),
    .din(din), .dout(dout), .busy(busy), .mode_q(mode_q), .cfg_q(cfg_q),
    .csh_q(csh_q), .cm_req(cm_req), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_wdata(cm_wdata), .cm_rdata(cm_rdata));

  initial for (int i = 0; i < 256; i++) mem[i] = 9'h1AA;

  always @(posedge clk) begin
    if (cm_req && cm_we) begin
      mem[cm_addr] <= cm_wdata;
      if (clr_phase) begin
        if (int'(cm_addr) != clr_next) clr_bad <= clr_bad + 1;
        clr_next <= clr_next + 1;
      end
    end
    if (cm_req && !cm_we) cm_rdata <= mem[cm_addr];
    if (busy) run_len <= run_len + 1;
    else if (run_len != 0) begin last_run <= run_len; run_len <= 0; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic adr, input logic [7:0] d);
    @(negedge clk); a0 = adr; din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic adr, output logic [7:0] d);
    @(negedge clk); a0 = adr; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); d = dout;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    int zeros = 0;
    clr_phase = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 mode reset", mode_q, 8'hFF);
    chk("R1 cfg reset", cfg_q, 8'hFF);
    chk("R1 csh reset", csh_q, 8'h00);
    bus_rd(1'b1, s);
    chk("R8 busy during clear", s[7], 1'b1);
    wait_idle();
    clr_phase = 1'b0;
    for (int i = 0; i < 256; i++) if (mem[i] == 9'h000) zeros++;
    chk("R8 all words cleared", zeros, 256);
    chk("R8 clear order", clr_bad, 0);
    chk("R8 clear count", clr_next, 256);
  endtask

  task automatic t_mode();
    logic [7:0] s;
    bus_wr(1'b1, 8'h5A);
    chk("R2 mode write", mode_q, 8'h5A);
    bus_rd(1'b1, s);
    chk("R2 status idle", s, 8'h00);
  endtask

  task automatic t_cm_write_busy();
    logic [7:0] s;
    bus_wr(1'b0, 8'h02); bus_wr(1'b0, 8'h37); bus_wr(1'b0, 8'hC4);
    bus_rd(1'b1, s);
    chk("R7 busy after transaction", s[7], 1'b1);
    bus_wr(1'b0, 8'hC1);
    wait_idle();
    chk("R4 memory write 9 bits", mem[8'h37], 9'h1C4);
    chk("R7 busy run length", last_run, BC);
    bus_rd(1'b1, s);
    chk("R7 write during busy ignored", s & 8'h60, 8'h00);
  endtask

  task automatic t_cm_kind10();
    bus_wr(1'b0, 8'h80); bus_wr(1'b0, 8'h05); bus_wr(1'b0, 8'h77);
    wait_idle();
    chk("R4 kind 10 is memory", mem[8'h05], 9'h077);
    chk("R4 cfg untouched", cfg_q, 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] s;
    bus_wr(1'b0, 8'hC0); bus_wr(1'b0, 8'hFE); bus_wr(1'b0, 8'h3C);
    wait_idle();
    chk("R4 cfg write", cfg_q, 8'h3C);
    chk("R4 no mem at FE", mem[8'hFE], 9'h000);
    bus_wr(1'b0, 8'hC0); bus_wr(1'b0, 8'hFD); bus_wr(1'b0, 8'h81);
    wait_idle();
    chk("R4 csh write", csh_q, 8'h81);
    bus_wr(1'b0, 8'hC1); bus_wr(1'b0, 8'hFE); bus_wr(1'b0, 8'h00);
    wait_idle();
    bus_rd(1'b0, s);
    chk("R5 cfg read back", s, 8'h3C);
    chk("R5 cfg unchanged by read", cfg_q, 8'h3C);
  endtask

  task automatic t_cm_read();
    logic [7:0] s;
    bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h37); bus_wr(1'b0, 8'h99);
    wait_idle();
    bus_rd(1'b0, s);
    chk("R5 memory read low", s, 8'hC4);
    bus_rd(1'b1, s);
    chk("R5 memory read bit8", s, 8'h01);
    chk("R5 read leaves memory", mem[8'h37], 9'h1C4);
  endtask

  task automatic t_interleave();
    logic [7:0] s;
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h11);
    bus_rd(1'b1, s);
    chk("R6 position after byte 1", s & 8'h60, 8'h20);
    bus_wr(1'b0, 8'h10);
    bus_rd(1'b1, s);
    chk("R6 position after byte 2", s & 8'h60, 8'h40);
    bus_wr(1'b1, 8'h22);
    bus_wr(1'b0, 8'h55);
    wait_idle();
    chk("R6 interleaved transaction", mem[8'h10], 9'h055);
    chk("R2 mode written mid sequence", mode_q, 8'h22);
  endtask

  task automatic t_held();
    logic [7:0] s;
    @(negedge clk); a0 = 1'b0; din = 8'h00; cs_n = 1'b0; wr_n = 1'b0;
    repeat (10) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    bus_rd(1'b1, s);
    chk("R9 held strobe acts once", s & 8'h60, 8'h20);
    bus_wr(1'b0, 8'h20); bus_wr(1'b0, 8'h66);
    wait_idle();
    chk("R3 completes after held byte", mem[8'h20], 9'h066);
    bus_rd(1'b1, s);
    chk("R3 position back to 0", s & 8'h60, 8'h00);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_mode();
    t_cm_write_busy();
    t_cm_kind10();
    t_regs();
    t_cm_read();
    t_interleave();
    t_held();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule